// File: doc/BRIEF.md
# Pipelined Prime-Field Multiplier, Modulus 2^255 - 19

This block multiplies two elements of the prime field with modulus p = 2^255 - 19 and returns the product in canonical form. Each operand is a 255-bit value split into fifteen 17-bit limbs, least significant limb first. The operands may be unreduced, meaning any value below 2^255. The datapath is fully pipelined: a new, independent operand pair can enter on every clock, and each result leaves a fixed number of cycles later. A valid bit and an 8-bit caller tag travel alongside the data, so a scheduler can interleave unrelated computations and match each result to its owner.

Inside, every output limb is formed as a dot product over all fifteen limb pairs. A pair whose combined weight reaches 2^255 wraps around to the low limb positions with a factor of 19, because 2^255 is congruent to 19 modulo p. Two registered carry passes shrink the wide accumulators back towards 17-bit limbs. A normalize stage folds any excess above bit 254, and a conditional subtraction of p makes the result canonical. Padding stages make the total depth equal to the latency parameter.

Top module: `fmul17_pipe`

## Requirements
- R1: Operands and result use 15 limbs of 17 bits, least significant first; limb k occupies bits [17k+16:17k] of the 255-bit port.
- R2: For any operands a, b below 2^255 (including values at or above p), the result equals a*b mod p.
- R3: The result is canonical: whenever out_valid is high, out_p is below p.
- R4: The latency is exactly 45 cycles. An operand pair held with in_valid high during cycle c produces its result with out_valid high during cycle c+45.
- R5: The initiation interval is 1. Back-to-back operand pairs on consecutive cycles each produce a result, and results leave in the order the operands entered.
- R6: out_tag equals the in_tag that accompanied the operand pair whose result is on out_p.
- R7: Limb products of weight 2^255 or above are folded with a factor of 19. For example, 2^254 times 2 gives 19.
- R8: No accumulator or carry overflow occurs for the largest operands. (2^255 - 1) squared gives 324.
- R9: While rst_n is low on a rising edge, all in-flight operations are discarded. out_valid stays low for the first 45 cycles after reset is released, and it is high only in cycles that are 45 after a cycle with in_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_tag | input | 8 | Caller tag carried with the operation |
| in_a | input | 255 | First operand, 15 x 17-bit limbs |
| in_b | input | 255 | Second operand, 15 x 17-bit limbs |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | 8 | Tag of the operation on out_p |
| out_p | output | 255 | Canonical product, 15 x 17-bit limbs |

## Verification
A wrong wrap index or a missing factor of 19 corrupts only products whose limb pairs cross 2^255, so the bench drives both dense random operands and sparse ones aimed at single limb pairs. A carry that is dropped or misrouted in either pass shows up as a wrong result exactly 45 cycles after the bad operands entered. It appears mostly on all-ones and near-p operands, where every carry chain is long. A slip in the valid or tag delay shows at once as a result arriving a cycle early or late, a result missing from a gapped stream, or tags out of order. Any of these is caught on the first affected output.

// File: rtl/fmul17_pkg.sv
// Shared constants and helpers for the radix-17 field multiplier.
// Assumes the modulus 2^(LIMB_W*NLIMB) - FOLD, so every wrap weighs FOLD.
package fmul17_pkg;
    localparam int LIMB_W  = 17;
    localparam int NLIMB   = 15;
    localparam int FIELD_W = LIMB_W * NLIMB;
    localparam int FOLD    = 19;
    localparam int FOLD_W  = $clog2(FOLD + 1);
    // row accumulator: 2*LIMB_W product bits plus growth from NLIMB terms x FOLD
    localparam int ACC_W   = 2 * LIMB_W + $clog2(NLIMB * FOLD) + 1;
    localparam logic [FIELD_W-1:0] MODULUS = {FIELD_W{1'b1}} - FIELD_W'(FOLD - 1);

    // output limb width of one carry pass for a given input limb width
    function automatic int carry_out_w(input int in_w);
        int c;
        c = in_w - LIMB_W + FOLD_W;
        return ((c > LIMB_W) ? c : LIMB_W) + 1;
    endfunction
endpackage

// File: rtl/fmul17_delay.sv
// Parameterised shift register; DEPTH stages, DEPTH may be zero (wire through).
// Assumes a synchronous active-low reset clears the stages only if CLEAR is 1.
module fmul17_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter bit CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [WIDTH-1:0] stage [DEPTH];
            // shift every stage one step per cycle
            always_ff @(posedge clk) begin
                if (CLEAR && !rst_n) begin
                    for (int s = 0; s < DEPTH; s++) stage[s] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int s = 1; s < DEPTH; s++) stage[s] <= stage[s-1];
                end
            end
            assign q = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/fmul17_conv.sv
// Wrapped 15x15 limb convolution: registers the operands, then registers one
// dot product per output limb. Pairs with i+j >= NLIMB wrap to limb i+j-NLIMB
// and are scaled by FOLD. Two cycles of latency, no stall.
module fmul17_conv
    import fmul17_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [FIELD_W-1:0]             a,
    input  logic [FIELD_W-1:0]             b,
    output logic [NLIMB-1:0][ACC_W-1:0]    acc
);
    logic [NLIMB-1:0][LIMB_W-1:0] a_q, b_q;
    logic [NLIMB-1:0][ACC_W-1:0]  row_sum;

    // capture operands as limb vectors
    always_ff @(posedge clk) begin
        a_q <= a;
        b_q <= b;
    end

    generate
        for (genvar k = 0; k < NLIMB; k++) begin : g_row
            // dot product for output limb k, wrapped terms times FOLD
            always_comb begin
                logic [ACC_W-1:0] s;
                s = '0;
                for (int i = 0; i < NLIMB; i++) begin
                    logic [ACC_W-1:0] prod;
                    int j;
                    j = (k - i + NLIMB) % NLIMB;
                    prod = ACC_W'(a_q[i]) * ACC_W'(b_q[j]);
                    if (i > k) s = s + prod * ACC_W'(FOLD);
                    else       s = s + prod;
                end
                row_sum[k] = s;
            end
        end
    endgenerate

    // register the row accumulators
    always_ff @(posedge clk) acc <= row_sum;

    generate
        for (genvar k = 0; k < NLIMB; k++) begin : g_chk
            // R8
            no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                acc[k][ACC_W-1] == 1'b0);
        end
    endgenerate
endmodule

// File: rtl/fmul17_carry.sv
// One registered carry pass: each limb keeps its low LIMB_W bits and gains the
// excess of the limb below; the excess of the top limb re-enters limb 0 times FOLD.
// The value modulo p is unchanged; limbs shrink towards LIMB_W bits.
module fmul17_carry
    import fmul17_pkg::*;
#(
    parameter int IN_W  = ACC_W,
    parameter int OUT_W = carry_out_w(ACC_W)
) (
    input  logic                          clk,
    input  logic [NLIMB-1:0][IN_W-1:0]    d,
    output logic [NLIMB-1:0][OUT_W-1:0]   q
);
    localparam int CW = IN_W - LIMB_W;

    logic [NLIMB-1:0][OUT_W-1:0] nxt;

    generate
        for (genvar k = 0; k < NLIMB; k++) begin : g_limb
            if (k == 0) begin : g_wrap
                // limb 0 takes the scaled top carry
                assign nxt[k] = OUT_W'(d[k][LIMB_W-1:0])
                              + OUT_W'(d[NLIMB-1][IN_W-1:LIMB_W]) * OUT_W'(FOLD);
            end else begin : g_plain
                // limb k takes the carry of limb k-1
                assign nxt[k] = OUT_W'(d[k][LIMB_W-1:0])
                              + OUT_W'(CW'(d[k-1][IN_W-1:LIMB_W]));
            end
        end
    endgenerate

    // register the pass result
    always_ff @(posedge clk) q <= nxt;
endmodule

// File: rtl/fmul17_final.sv
// Normalize and reduce: sums the limbs into one integer, folds bits at and above
// 2^FIELD_W by FOLD, then subtracts p once if needed. Assumes the input value
// is below 2^(FIELD_W+4) so one fold leaves less than 2p. Two cycles of latency.
module fmul17_final
    import fmul17_pkg::*;
#(
    parameter int IN_W = 22
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NLIMB-1:0][IN_W-1:0]    d,
    output logic [FIELD_W-1:0]            res
);
    localparam int NW = FIELD_W + 4;

    logic [NW-1:0]      total;
    logic [FIELD_W:0]   folded_n, folded_q;

    // flatten limbs into one integer and fold the high bits
    always_comb begin
        total = '0;
        for (int k = 0; k < NLIMB; k++)
            total = total + (NW'(d[k]) << (LIMB_W * k));
        folded_n = (FIELD_W+1)'(total[FIELD_W-1:0])
                 + (FIELD_W+1)'(total[NW-1:FIELD_W]) * (FIELD_W+1)'(FOLD);
    end

    // register the folded value
    always_ff @(posedge clk) folded_q <= folded_n;

    // conditional subtraction of p
    always_ff @(posedge clk) begin
        if (folded_q >= {1'b0, MODULUS}) res <= FIELD_W'(folded_q - {1'b0, MODULUS});
        else                             res <= folded_q[FIELD_W-1:0];
    end

    // R3
    fold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        folded_q < ({1'b0, MODULUS} << 1));
endmodule

// File: rtl/fmul17_pipe.sv
// Top of the pipelined field multiplier over GF(2^255 - 19). One operand pair
// per cycle, fixed LATENCY, valid and tag delayed alongside the data. Assumes
// LATENCY >= CORE_DEPTH; the surplus is padding stages after the reduction.
module fmul17_pipe
    import fmul17_pkg::*;
#(
    parameter int TAG_W   = 8,
    parameter int LATENCY = 45
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [TAG_W-1:0]   in_tag,
    input  logic [254:0]       in_a,
    input  logic [254:0]       in_b,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag,
    output logic [254:0]       out_p
);
    localparam int CORE_DEPTH = 6;
    localparam int PAD        = LATENCY - CORE_DEPTH;
    localparam int W1         = carry_out_w(ACC_W);
    localparam int W2         = carry_out_w(W1);
    localparam int AGE_W      = $clog2(LATENCY + 1);

    logic [NLIMB-1:0][ACC_W-1:0] acc;
    logic [NLIMB-1:0][W1-1:0]    pass1;
    logic [NLIMB-1:0][W2-1:0]    pass2;
    logic [FIELD_W-1:0]          reduced;

    fmul17_conv i_conv (
        .clk (clk), .rst_n (rst_n), .a (in_a), .b (in_b), .acc (acc)
    );

    fmul17_carry #(.IN_W(ACC_W), .OUT_W(W1)) i_carry1 (
        .clk (clk), .d (acc), .q (pass1)
    );

    fmul17_carry #(.IN_W(W1), .OUT_W(W2)) i_carry2 (
        .clk (clk), .d (pass1), .q (pass2)
    );

    fmul17_final #(.IN_W(W2)) i_final (
        .clk (clk), .rst_n (rst_n), .d (pass2), .res (reduced)
    );

    fmul17_delay #(.WIDTH(FIELD_W), .DEPTH(PAD), .CLEAR(1'b0)) i_pad (
        .clk (clk), .rst_n (rst_n), .d (reduced), .q (out_p)
    );

    fmul17_delay #(.WIDTH(TAG_W + 1), .DEPTH(LATENCY), .CLEAR(1'b1)) i_ctl (
        .clk (clk), .rst_n (rst_n), .d ({in_valid, in_tag}), .q ({out_valid, out_tag})
    );

    // cycles since reset release, saturating at LATENCY (checking aid)
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)                     age <= '0;
        else if (age != AGE_W'(LATENCY)) age <= age + 1'b1;
    end

    // R9
    early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age < AGE_W'(LATENCY)) |-> !out_valid);

    // R3
    canonical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_p < MODULUS));

    generate
        for (genvar k = 1; k < NLIMB; k++) begin : g_bound
            // R8
            carry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pass2[k][W2-1:LIMB_W+1] == '0);
        end
    endgenerate
endmodule

// File: tb/test_fmul17_pipe.sv
// Directed bench for fmul17_pipe: one task per scenario, shared scoreboard.
module test_fmul17_pipe;
    localparam logic [254:0] P = {255{1'b1}} - 255'd18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_tag = '0;
    logic [254:0] in_a = '0, in_b = '0;
    logic         out_valid;
    logic [7:0]   out_tag;
    logic [254:0] out_p;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit mon_en = 1'b1;
    bit done = 1'b0;

    logic [254:0] exp_val [1024];
    logic [7:0]   exp_tag [1024];
    int           exp_cyc [1024];
    int           wr_ptr = 0, rd_ptr = 0;
    string        cur_req = "R2";

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fmul17_pipe i_fmul17_pipe (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_tag (in_tag),
        .in_a (in_a), .in_b (in_b), .out_valid (out_valid), .out_tag (out_tag),
        .out_p (out_p)
    );

    function automatic logic [254:0] ref_mul(input logic [254:0] a, input logic [254:0] b);
        logic [256:0] r, ar;
        ar = {2'b00, a};
        if (ar >= {2'b00, P}) ar = ar - {2'b00, P};
        r = '0;
        for (int i = 254; i >= 0; i--) begin
            r = r << 1;
            if (r >= {2'b00, P}) r = r - {2'b00, P};
            if (b[i]) r = r + ar;
            if (r >= {2'b00, P}) r = r - {2'b00, P};
        end
        return r[254:0];
    endfunction

    function automatic logic [254:0] rnd255();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v[254:0];
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // scoreboard: compare value, tag and arrival cycle for every result
    always @(negedge clk) begin
        if (mon_en && rst_n && out_valid) begin
            if (rd_ptr == wr_ptr) begin
                check(1'b0, "R9", $sformatf("unexpected result cycle %0d actual tag %0h expected none", cyc, out_tag));
            end else begin
                check(out_p == exp_val[rd_ptr], cur_req,
                      $sformatf("value actual %h expected %h", out_p, exp_val[rd_ptr]));
                check(out_tag == exp_tag[rd_ptr], "R6",
                      $sformatf("tag actual %0h expected %0h", out_tag, exp_tag[rd_ptr]));
                check(cyc == exp_cyc[rd_ptr] + 45, "R4",
                      $sformatf("arrival cycle actual %0d expected %0d", cyc, exp_cyc[rd_ptr] + 45));
                check(out_p < P, "R3", $sformatf("non-canonical actual %h expected below p", out_p));
                rd_ptr++;
            end
        end
    end

    task automatic issue(input logic [254:0] a, input logic [254:0] b, input bit record);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        in_tag = 8'(wr_ptr * 37 + 5);
        if (record) begin
            exp_val[wr_ptr] = ref_mul(a, b);
            exp_tag[wr_ptr] = in_tag;
            exp_cyc[wr_ptr] = cyc;
            wr_ptr++;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain(input string req);
        idle(50);
        check(rd_ptr == wr_ptr, req, $sformatf("results actual %0d expected %0d", rd_ptr, wr_ptr));
    endtask

    // R9: reset state and quiet start-up window
    task automatic t_reset_state();
        int seen;
        seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, "R9", $sformatf("valid during start-up actual %0d expected 0", seen));
    endtask

    // R1 R7 R8: edge operands
    task automatic t_edges();
        logic [254:0] one, pm1, ones, h254, two;
        one = 255'd1; pm1 = P - 255'd1; ones = {255{1'b1}};
        h254 = 255'd1 << 254; two = 255'd2;
        cur_req = "R7";
        issue(h254, two, 1);
        issue(255'd1 << 238, 255'd1 << 17, 1);   // single limb pair 14 x 1 wraps to limb 0
        cur_req = "R8";
        issue(ones, ones, 1);
        issue(pm1, pm1, 1);
        issue(P, 255'd5, 1);
        issue('0, ones, 1);
        issue(one, pm1, 1);
        issue(255'h1FFFF, 255'h1FFFF << 17, 1);  // R1 limb ordering
        idle(1);
        check(ref_mul(ones, ones) == 255'd324, "R8", "reference for all-ones square");
        check(ref_mul(h254, two) == 255'd19, "R7", "reference for 2^254*2");
        drain("R8");
    endtask

    // R5: back-to-back random stream
    task automatic t_stream();
        cur_req = "R5";
        for (int i = 0; i < 200; i++) issue(rnd255(), rnd255(), 1);
        drain("R5");
    endtask

    // R2: random operands near p and near 2^255, with gaps
    task automatic t_gapped();
        cur_req = "R2";
        for (int i = 0; i < 60; i++) begin
            logic [254:0] a;
            a = (i % 2 == 0) ? P - 255'($urandom_range(0, 40)) : {255{1'b1}} - 255'($urandom_range(0, 40));
            issue(a, rnd255(), 1);
            if (i % 3 == 0) idle(i % 5);
        end
        drain("R2");
    endtask

    // R9: reset discards in-flight work
    task automatic t_mid_reset();
        int seen;
        seen = 0;
        mon_en = 1'b0;
        for (int i = 0; i < 10; i++) issue(rnd255(), rnd255(), 0);
        idle(20);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        mon_en = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, "R9", $sformatf("valid after reset actual %0d expected 0", seen));
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_edges();
        t_stream();
        t_gapped();
        t_mid_reset();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run actual unfinished expected finished");
            report();
        end
    end
endmodule